// File: doc/BRIEF.md
# Read-Snooping Termination Enable Controller

This block drives the on-die termination enables of a graphics DRAM device. Every clock it looks at the decoded READ strobe from the command decoder. When a READ appears it opens a window in which the termination on the data and read-strobe pins is switched off, so that the driving device sees an unloaded line. The READ does not have to be addressed to this rank, and the chip-select level is ignored. Every device sharing the bus therefore releases its termination for reads aimed at any of them.

The window opens a fixed number of cycles after the READ, derived from the programmed CAS latency. Its length comes from the programmed burst length. READs whose windows overlap or touch merge into one continuous off period.

Three extended-mode-register bits can permanently disable the termination of the data group, the write-strobe group and the data-mask group. The remaining address and command pins keep their termination on at all times. CAS latency, burst length and the disable bits are static configuration, changed only while in reset or with no READ pending.

Top module: `odt_snoop_ctrl`

## Requirements
- R1: After reset there is no pending off window: each of the three maskable enables equals the inverse of its disable bit, and the command-pin enable is high.
- R2: A READ strobe (`rd_cmd_i` high at a rising edge) opens an off window whether `cs_n_i` is high or low.
- R3: `term_dq_en_o` goes low right after the rising edge that lies CL−1 cycles after the edge where the READ was sampled. CL is `cas_lat_i` limited to 2..15, and values 0 and 1 act as 2.
- R4: A single window keeps `term_dq_en_o` low for exactly BL/2+2 cycles. BL is 4 when `burst_len8_i` is 0 and 8 when it is 1, giving 4 and 6 cycles.
- R5: When the window of a later READ overlaps or directly follows an earlier one, `term_dq_en_o` stays low without a gap until the end of the latest window.
- R6: `term_wdqs_en_o` always equals the inverse of `emr_wdqs_off_i`, and READs have no effect on it.
- R7: `term_dm_en_o` always equals the inverse of `emr_dm_off_i`, and READs have no effect on it.
- R8: `term_ctl_en_o` is high at all times, whatever the READ traffic and the disable bits.
- R9: While `emr_dq_off_i` is high, `term_dq_en_o` is low regardless of READ traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_cmd_i | input | 1 | Decoded READ strobe, one cycle per command |
| cs_n_i | input | 1 | Chip select, active low (does not gate snooping) |
| cas_lat_i | input | 4 | Programmed CAS latency |
| burst_len8_i | input | 1 | Burst length select: 0 gives BL4, 1 gives BL8 |
| emr_dq_off_i | input | 1 | Mode-register disable for data/read-strobe termination |
| emr_wdqs_off_i | input | 1 | Mode-register disable for write-strobe termination |
| emr_dm_off_i | input | 1 | Mode-register disable for data-mask termination |
| term_dq_en_o | output | 1 | Termination enable, data and read-strobe pins |
| term_wdqs_en_o | output | 1 | Termination enable, write-strobe pins |
| term_dm_en_o | output | 1 | Termination enable, data-mask pins |
| term_ctl_en_o | output | 1 | Termination enable, address/command pins |

## Verification
A wrong stage in the READ delay line or a wrong tap choice moves the falling edge of `term_dq_en_o` by whole cycles. This shows on the first READ after reset, within CL cycles. A wrong reload or decrement in the off counter shows as a window that is too short, too long or split. Closely spaced READs expose it within BL/2+2 cycles of the start of the window. The bench compares every enable on every cycle against a timeline rebuilt from the READ history, so any single-cycle error is reported in the cycle where it occurs.

// File: rtl/odt_pkg.sv
package odt_pkg;
  localparam int CL_W     = 4;
  localparam int CL_MIN   = 2;
  localparam int CL_MAX   = 15;
  localparam int BL_SHORT = 4;
  localparam int BL_LONG  = 8;
  // window length in cycles for each burst choice
  localparam int WIN_SHORT = BL_SHORT / 2 + 2;
  localparam int WIN_LONG  = BL_LONG / 2 + 2;
  localparam int WIN_W     = $clog2(WIN_LONG + 1);
  localparam int DLY_DEPTH = CL_MAX - 1;
  localparam int TAP_W     = $clog2(DLY_DEPTH);
endpackage

// File: rtl/odt_read_delay.sv
module odt_read_delay
  import odt_pkg::*;
#(
  parameter int DEPTH = DLY_DEPTH,
  parameter int TW    = TAP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_i,
  input  logic [TW-1:0] tap_i,
  output logic          start_o,
  output logic          busy_o
);
  logic [DEPTH-1:0] stage_q;

  // stage j holds a READ sampled j+1 edges ago
  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[g] <= 1'b0;
          else        stage_q[g] <= rd_i;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[g] <= 1'b0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign start_o = stage_q[tap_i];
  assign busy_o  = |stage_q;

  AST_TAP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tap_i) < DEPTH); // R3
  AST_READ_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> busy_o); // R2
endmodule

// File: rtl/odt_off_timer.sv
module odt_off_timer
  import odt_pkg::*;
#(
  parameter int CW = WIN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] len_i,
  output logic          off_o
);
  logic [CW-1:0] cnt_q;

  // a new start reloads the full length: the latest window always ends last
  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (start_i)       cnt_q <= len_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign off_o = (cnt_q != '0);

  AST_START_TURNS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> off_o); // R3
  AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (off_o && !start_i && cnt_q > 1) |=> off_o); // R5
  AST_RELEASE_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && cnt_q == 1) |=> !off_o); // R4
endmodule

// File: rtl/odt_snoop_ctrl.sv
module odt_snoop_ctrl
  import odt_pkg::*;
#(
  parameter int CLW = CL_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_cmd_i,
  input  logic           cs_n_i,
  input  logic [CLW-1:0] cas_lat_i,
  input  logic           burst_len8_i,
  input  logic           emr_dq_off_i,
  input  logic           emr_wdqs_off_i,
  input  logic           emr_dm_off_i,
  output logic           term_dq_en_o,
  output logic           term_wdqs_en_o,
  output logic           term_dm_en_o,
  output logic           term_ctl_en_o
);
  logic [CLW-1:0]   cl_eff;
  logic [TAP_W-1:0] tap;
  logic [WIN_W-1:0] win_len;
  logic             start;
  logic             rd_busy;
  logic             dq_off;

  // limit latency to the legal range, then point at the stage CL-2
  always_comb begin
    if (int'(cas_lat_i) < CL_MIN)      cl_eff = CLW'(CL_MIN);
    else if (int'(cas_lat_i) > CL_MAX) cl_eff = CLW'(CL_MAX);
    else                               cl_eff = cas_lat_i;
    tap     = TAP_W'(cl_eff - CLW'(CL_MIN));
    win_len = burst_len8_i ? WIN_W'(WIN_LONG) : WIN_W'(WIN_SHORT);
  end

  // chip select deliberately plays no part: every rank snoops every READ
  odt_read_delay #(.DEPTH(DLY_DEPTH), .TW(TAP_W)) u_dly (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_i    (rd_cmd_i),
    .tap_i   (tap),
    .start_o (start),
    .busy_o  (rd_busy)
  );

  odt_off_timer #(.CW(WIN_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .len_i   (win_len),
    .off_o   (dq_off)
  );

  assign term_dq_en_o   = !emr_dq_off_i && !dq_off;
  assign term_wdqs_en_o = !emr_wdqs_off_i;
  assign term_dm_en_o   = !emr_dm_off_i;
  assign term_ctl_en_o  = 1'b1;

  AST_SNOOP_ANY_RANK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd_i && cs_n_i) |=> (rd_busy || dq_off)); // R2
  AST_WDQS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(emr_wdqs_off_i) |-> $stable(term_wdqs_en_o)); // R6
  AST_DM_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(emr_dm_off_i) |-> $stable(term_dm_en_o)); // R7
  AST_DQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    emr_dq_off_i |-> !term_dq_en_o); // R9
endmodule

// File: tb/sim_odt_snoop_ctrl.sv
module sim_odt_snoop_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_cmd = 1'b0;
  logic       cs_n = 1'b1;
  logic [3:0] cas_lat = 4'd5;
  logic       bl8 = 1'b0;
  logic       emr_dq = 1'b0, emr_wdqs = 1'b0, emr_dm = 1'b0;
  logic       dq_en, wdqs_en, dm_en, ctl_en;

  int checks = 0;
  int errors = 0;
  bit hist [0:1023];
  bit done = 1'b0;

  always #5 clk = ~clk;

  odt_snoop_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .rd_cmd_i(rd_cmd), .cs_n_i(cs_n),
    .cas_lat_i(cas_lat), .burst_len8_i(bl8),
    .emr_dq_off_i(emr_dq), .emr_wdqs_off_i(emr_wdqs), .emr_dm_off_i(emr_dm),
    .term_dq_en_o(dq_en), .term_wdqs_en_o(wdqs_en),
    .term_dm_en_o(dm_en), .term_ctl_en_o(ctl_en)
  );

  function automatic int eff_cl(input logic [3:0] c);
    return (c < 2) ? 2 : int'(c);
  endfunction

  function automatic int win_len(input logic b);
    return b ? 6 : 4;
  endfunction

  // off after edge t if a READ at edge k covers k+CL-1 .. k+CL+LEN-2
  function automatic bit exp_off(input int t);
    int cl, ln;
    bit o;
    cl = eff_cl(cas_lat);
    ln = win_len(bl8);
    o = 1'b0;
    for (int k = 0; k <= t; k++)
      if (hist[k] && t >= k + cl - 1 && t <= k + cl + ln - 2) o = 1'b1;
    return o;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp, input int t);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %b expected %b", req, t, act, exp);
    end
  endtask

  task automatic check_all(input int t, input bit in_reset);
    bit off;
    off = in_reset ? 1'b0 : exp_off(t);
    chk(in_reset ? "R1" : (emr_dq ? "R9" : "R3/R4/R5"), dq_en, !emr_dq && !off, t);
    chk(in_reset ? "R1" : "R6", wdqs_en, !emr_wdqs, t);
    chk(in_reset ? "R1" : "R7", dm_en, !emr_dm, t);
    chk(in_reset ? "R1" : "R8", ctl_en, 1'b1, t);
  endtask

  // mode 0: random traffic; mode 1: directed back-to-back, touching, gap
  task automatic run_cfg(input logic [3:0] cl, input logic b, input logic ed,
                         input logic ew, input logic em, input int mode, input int n);
    int ln;
    @(negedge clk);
    rst_n = 1'b0; rd_cmd = 1'b0;
    cas_lat = cl; bl8 = b; emr_dq = ed; emr_wdqs = ew; emr_dm = em;
    for (int k = 0; k < 1024; k++) hist[k] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all(-1, 1'b1); // R1 reset state
    ln = win_len(b);
    for (int i = 0; i < n; i++) begin
      logic r;
      if (mode == 1)
        r = (i == 2) || (i == 3) || (i == 3 + ln) || (i == 4 + 2 * ln) || (i == 40);
      else
        r = ($urandom_range(0, 5) == 0);
      rd_cmd = r;
      cs_n = $urandom_range(0, 1); // R2: chip select must not matter
      hist[i] = r;
      @(posedge clk);
      @(negedge clk);
      check_all(i, 1'b0);
    end
    rd_cmd = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    run_cfg(4'd5,  1'b0, 1'b0, 1'b0, 1'b0, 1, 60);  // R5 directed
    run_cfg(4'd5,  1'b1, 1'b0, 1'b0, 1'b0, 1, 60);
    run_cfg(4'd2,  1'b0, 1'b0, 1'b0, 1'b0, 1, 60);  // R3 minimum latency
    run_cfg(4'd15, 1'b1, 1'b0, 1'b0, 1'b0, 1, 60);  // R3 maximum latency
    run_cfg(4'd1,  1'b0, 1'b0, 1'b0, 1'b0, 0, 200); // R3 clamp to 2
    run_cfg(4'd0,  1'b1, 1'b0, 1'b0, 1'b0, 0, 200);
    run_cfg(4'd7,  1'b1, 1'b0, 1'b0, 1'b0, 0, 400); // R2/R4 random
    run_cfg(4'd11, 1'b0, 1'b0, 1'b0, 1'b0, 0, 400);
    run_cfg(4'd6,  1'b0, 1'b1, 1'b0, 1'b0, 0, 200); // R9
    run_cfg(4'd6,  1'b1, 1'b0, 1'b1, 1'b0, 0, 200); // R6
    run_cfg(4'd9,  1'b0, 1'b0, 1'b0, 1'b1, 0, 200); // R7
    run_cfg(4'd3,  1'b1, 1'b1, 1'b1, 1'b1, 0, 200); // R8 with all disables
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule